// File: doc/BRIEF.md
# Sixteen-bit two-level lookahead adder/subtractor

This block is a purely combinational adder/subtractor for two 16-bit words. The word is split into four 4-bit groups. Inside each group, the carry into every bit is formed as a flat sum of products of per-bit generate and propagate terms. Each group also reduces those terms to one group generate and one group propagate. A second lookahead stage, built the same way, takes these four pairs and the carry-in. It forms the carries into bits 4, 8, 12 and 16 side by side, so no carry ripples from one group to the next.

A single `subtract` pin selects the operation. When it is low, the block adds the two operands and the carry-in. When it is high, the block inverts the second operand, forces the low carry to one, and so returns A minus B. The carry-out is reported as the adder produces it, so in subtract mode a one means no borrow. The signed-overflow flag compares the sign bits of the operands that actually reach the adder. The block has no clock, no state and no handshake: results follow the inputs through logic alone.

Top module: `cla_addsub16`

## Requirements
- R1: With `subtract`=0, `result` equals (op_a + op_b + carry_in) mod 2^16.
- R2: With `subtract`=0, `carry_out` equals bit 16 of the unsigned sum op_a + op_b + carry_in.
- R3: With `subtract`=1, `result` equals (op_a − op_b) mod 2^16, and `carry_in` has no effect on any output.
- R4: With `subtract`=1, `carry_out` is 1 exactly when op_a ≥ op_b as unsigned numbers (no borrow). It is not inverted.
- R5: With `subtract`=0, `overflow` is 1 exactly when the two's-complement sum op_a + op_b + carry_in lies outside −32768..32767. For example, 0x7FFF+1 gives 1 and 0xFFFF+1 gives 0.
- R6: With `subtract`=1, `overflow` is 1 exactly when the two's-complement difference op_a − op_b lies outside −32768..32767. For example, 0x8000−1 gives 1.
- R7: A carry entering at bit 0 reaches bit 16 when every bit propagates. For example, 0xFFFF+0 with carry_in=1 gives result 0 and carry_out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First operand (minuend when subtracting) |
| op_b | input | 16 | Second operand (subtrahend when subtracting) |
| carry_in | input | 1 | Carry into bit 0; used only when adding |
| subtract | input | 1 | 0 selects add, 1 selects subtract |
| result | output | 16 | Sum or difference |
| carry_out | output | 1 | Carry out of bit 15; 1 means no borrow when subtracting |
| overflow | output | 1 | Two's-complement overflow of the selected operation |

## Verification
Every output is due in the same cycle as its stimulus, with zero register stages between the pins. The bench therefore drives the operands on a falling clock edge and samples all three outputs one nanosecond later, before the next rising edge. It sweeps every pair from a set of boundary words in all four combinations of mode and carry-in, and then runs thousands of pseudo-random vectors. The expected values come from integer arithmetic, both unsigned and signed.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned DEF_GROUP_W = 4;
  localparam int unsigned DEF_GROUPS  = 4;

  typedef struct packed {
    logic gen;
    logic prop;
  } gp_pair_t;
endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin,
  output logic [N:0]   carry,
  output cla_pkg::gp_pair_t grp
);
  // Each carry is a flat OR of product terms; no term uses another carry.
  always_comb begin
    logic acc;
    logic prod;
    carry[0] = cin;
    for (int i = 0; i < N; i++) begin
      acc = 1'b0;
      for (int j = 0; j <= i; j++) begin
        prod = gen_i[j];
        for (int k = j + 1; k <= i; k++) prod = prod & prop_i[k];
        acc = acc | prod;
      end
      prod = cin;
      for (int k = 0; k <= i; k++) prod = prod & prop_i[k];
      carry[i+1] = acc | prod;
    end
  end

  always_comb begin
    logic acc;
    logic prod;
    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      prod = gen_i[j];
      for (int k = j + 1; k < N; k++) prod = prod & prop_i[k];
      acc = acc | prod;
    end
    grp.gen = acc;
    prod = 1'b1;
    for (int k = 0; k < N; k++) prod = prod & prop_i[k];
    grp.prop = prod;
  end

  always_comb begin
    // R7
    lookahead_grp_chk: assert (carry[N] == (grp.gen | (grp.prop & cin)))
      else $error("group terms disagree with top carry");
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output cla_pkg::gp_pair_t grp
);
  logic [W-1:0] g_bit, p_bit;
  logic [W:0]   c_bit;

  assign g_bit = a & b;
  assign p_bit = a ^ b;

  cla_lookahead #(.N(W)) u_la (
    .gen_i (g_bit),
    .prop_i(p_bit),
    .cin   (cin),
    .carry (c_bit),
    .grp   (grp)
  );

  assign sum = p_bit ^ c_bit[W-1:0];

  always_comb begin
    // R1
    group_sum_chk: assert ({c_bit[W], sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
      else $error("group sum mismatch");
  end
endmodule

// File: rtl/cla_addsub16.sv
module cla_addsub16 #(
  parameter int unsigned GROUP_W = cla_pkg::DEF_GROUP_W,
  parameter int unsigned GROUPS  = cla_pkg::DEF_GROUPS
) (
  input  logic [GROUP_W*GROUPS-1:0] op_a,
  input  logic [GROUP_W*GROUPS-1:0] op_b,
  input  logic                      carry_in,
  input  logic                      subtract,
  output logic [GROUP_W*GROUPS-1:0] result,
  output logic                      carry_out,
  output logic                      overflow
);
  localparam int unsigned DW  = GROUP_W * GROUPS;
  localparam int unsigned MSB = DW - 1;

  logic [DW-1:0]     b_eff;
  logic              cin_eff;
  logic [GROUPS-1:0] grp_g, grp_p;
  logic [GROUPS:0]   grp_c;
  cla_pkg::gp_pair_t top_gp;

  assign b_eff   = subtract ? ~op_b : op_b;
  assign cin_eff = subtract | carry_in;

  for (genvar gi = 0; gi < GROUPS; gi++) begin : g_grp
    cla_pkg::gp_pair_t gp_one;
    cla_group #(.W(GROUP_W)) u_grp (
      .a  (op_a[gi*GROUP_W +: GROUP_W]),
      .b  (b_eff[gi*GROUP_W +: GROUP_W]),
      .cin(grp_c[gi]),
      .sum(result[gi*GROUP_W +: GROUP_W]),
      .grp(gp_one)
    );
    assign grp_g[gi] = gp_one.gen;
    assign grp_p[gi] = gp_one.prop;
  end

  cla_lookahead #(.N(GROUPS)) u_top (
    .gen_i (grp_g),
    .prop_i(grp_p),
    .cin   (cin_eff),
    .carry (grp_c),
    .grp   (top_gp)
  );

  assign carry_out = grp_c[GROUPS];
  assign overflow  = (op_a[MSB] == b_eff[MSB]) & (result[MSB] != op_a[MSB]);

  always_comb begin
    // R1
    word_sum_chk: assert ({carry_out, result} ==
                          ({1'b0, op_a} + {1'b0, b_eff} + {{DW{1'b0}}, cin_eff}))
      else $error("word sum mismatch");
    // R4
    no_borrow_chk: assert (!subtract || (carry_out == (op_a >= op_b)))
      else $error("borrow flag wrong");
    // R6
    ovf_sign_chk: assert (!overflow || (op_a[MSB] == (subtract ? !op_b[MSB] : op_b[MSB])))
      else $error("overflow with unlike signs");
    // R7
    top_gp_chk: assert (carry_out == (top_gp.gen | (top_gp.prop & cin_eff)))
      else $error("top group terms mismatch");
  end
endmodule

// File: tb/sim_cla_addsub16.sv
module sim_cla_addsub16;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] a, b, res;
  logic        cin, sub, cout, ovf;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  cla_addsub16 u0 (
    .op_a(a), .op_b(b), .carry_in(cin), .subtract(sub),
    .result(res), .carry_out(cout), .overflow(ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%0d sub=%0d actual=%0h expected=%0h",
               req, a, b, cin, sub, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] ta, input logic [15:0] tb_, input logic tc, input logic ts);
    int sa, sb, sres;
    logic [16:0] full;
    @(negedge clk);
    a = ta; b = tb_; cin = tc; sub = ts;
    #1;
    sa = $signed(ta);
    sb = $signed(tb_);
    if (!ts) begin
      full = {1'b0, ta} + {1'b0, tb_} + {16'd0, tc};
      sres = sa + sb + int'(tc);
      chk("R1 sum", int'(res), int'(full[15:0]));
      chk("R2 carry", int'(cout), int'(full[16]));
      chk("R5 overflow", int'(ovf), int'(sres > 32767 || sres < -32768));
    end else begin
      sres = sa - sb;
      chk("R3 difference", int'(res), int'(16'(ta - tb_)));
      chk("R4 no-borrow", int'(cout), int'(ta >= tb_));
      chk("R6 overflow", int'(ovf), int'(sres > 32767 || sres < -32768));
    end
  endtask

  logic [15:0] corner [12] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hFFFE,
                               16'h0FFF, 16'h00FF, 16'hF000, 16'h5555, 16'hAAAA, 16'h1234};

  initial begin
    logic [31:0] lfsr;
    logic [15:0] r0, r1;
    a = '0; b = '0; cin = 1'b0; sub = 1'b0;
    #1;
    // R1 quiescent state: all-zero inputs give all-zero outputs
    chk("R1 idle result", int'(res), 0);
    chk("R2 idle carry", int'(cout), 0);
    chk("R5 idle overflow", int'(ovf), 0);

    // named corners
    apply(16'h7FFF, 16'h0001, 1'b0, 1'b0);
    chk("R5 7FFF+1 ovf", int'(ovf), 1);
    apply(16'h8000, 16'h0001, 1'b0, 1'b1);
    chk("R6 8000-1 ovf", int'(ovf), 1);
    chk("R3 8000-1 res", int'(res), 16'h7FFF);
    apply(16'hFFFF, 16'h0001, 1'b0, 1'b0);
    chk("R2 FFFF+1 carry", int'(cout), 1);
    chk("R5 FFFF+1 no ovf", int'(ovf), 0);
    apply(16'hFFFF, 16'h0000, 1'b1, 1'b0);
    chk("R7 full propagate res", int'(res), 0);
    chk("R7 full propagate carry", int'(cout), 1);
    // R3: carry_in ignored when subtracting
    apply(16'h1234, 16'h0234, 1'b1, 1'b1);
    chk("R3 cin ignored", int'(res), 16'h1000);
    apply(16'h0003, 16'h0005, 1'b0, 1'b1);
    chk("R4 borrow", int'(cout), 0);

    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          apply(corner[i], corner[j], m[0], m[1]);

    lfsr = 32'hACE1_1357;
    for (int n = 0; n < 12000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      r0 = lfsr[15:0] ^ lfsr[31:16];
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      r1 = lfsr[31:16] + 16'(n);
      apply(r0, r1, lfsr[3], lfsr[7]);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule